// File: doc/BRIEF.md
# Defect-Triggered PLL Handover Timer

This block decides when a disc read channel may return clock recovery from its digital PLL to its analog PLL after the media defect detector has flagged a damaged area. The defect flag is sampled once per frame strobe. The block measures how many frames the defect lasts. When the flag falls, it holds the digital PLL selected for a further number of frames. That hold-off depends on whether the defect was short or long and on a range-select input.

A defect is long when it was seen on 12 or more frame strobes, and short when it was seen on fewer. With the range input low, the hold-off is 8 frames for a short defect and 16 for a long one. With the range input high, both values are halved to 4 and 8. If a new defect appears while the hold-off is running, the hold-off is dropped, the measurement starts again from zero and the digital PLL stays selected.

Top module: `pll_handover_timer`

## Requirements
- R1: While `rst_n` is low at a clock edge, `dpll_active` is 0 from the next cycle, and all measurement and hold-off state is cleared.
- R2: `defect_in` and `narrow_range` are looked at only in cycles where `frame_tick` is 1. Changing them in other cycles has no effect on `dpll_active`.
- R3: In the cycle after a frame strobe that samples `defect_in` = 1, `dpll_active` is 1.
- R4: The defect width is the number of consecutive strobes that sample `defect_in` = 1. A width of 11 is short and a width of 12 is long. The width count saturates at 12, so any longer defect is also long.
- R5: Call the first strobe that samples `defect_in` = 0 after a defect the fall strobe. With `narrow_range` = 0 at the fall strobe and a short defect, `dpll_active` stays 1 through the 7th following strobe and is 0 in the cycle after the 8th following strobe.
- R6: With `narrow_range` = 0 at the fall strobe and a long defect, `dpll_active` is 0 after the 16th strobe that follows the fall strobe, and is 1 before that.
- R7: With `narrow_range` = 1 at the fall strobe, the hold-off is 4 strobes for a short defect and 8 strobes for a long defect.
- R8: A strobe that samples `defect_in` = 1 during the hold-off keeps `dpll_active` at 1, cancels the hold-off and restarts the width count at one. The next hold-off is then based only on the new defect.
- R9: `dpll_active` changes only in the cycle after a frame strobe, or after reset.
- R10: `narrow_range` is taken once, at the fall strobe. Changing it during the hold-off does not change the length of the hold-off.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| frame_tick | input | 1 | One-cycle strobe, once per frame |
| defect_in | input | 1 | Media defect flag, 1 while a defect is present |
| narrow_range | input | 1 | 1 halves both hold-off lengths |
| dpll_active | output | 1 | 1 while the digital PLL must stay selected |

## Verification
The assertions assume that `frame_tick` is a single-cycle pulse and that the defect flag means something only in strobe cycles. They do not assume that `defect_in` is stable between strobes. The stimulus applies each strobe for exactly one cycle, with idle cycles in between. During those idle cycles it deliberately inverts `defect_in` and `narrow_range`, so that any sampling outside a strobe shows up at the output. Reset is applied only on whole clock edges, once at start-up and once in the middle of a hold-off.

// File: rtl/pll_handover_pkg.sv
// Shared types for the PLL handover timer.
// Assumes nothing beyond IEEE 1800-2017 enum support.
package pll_handover_pkg;

    // Control phase: no defect, defect being measured, hold-off counting.
    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_DEFECT = 2'd1,
        PH_HOLD   = 2'd2
    } phase_e;

endpackage

// File: rtl/defect_width_meter.sv
// Counts the frames on which a defect was seen and flags a long defect.
// Assumes start_i and inc_i are never high together; start_i restarts at one.
module defect_width_meter #(
    parameter int unsigned LONG_THRESH = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic inc_i,
    output logic long_o
);
    localparam int unsigned CW = $clog2(LONG_THRESH + 1);
    localparam logic [CW-1:0] SAT = CW'(LONG_THRESH);

    logic [CW-1:0] cnt_q;

    // Width count: restart, saturating increment, or hold.
    always_ff @(posedge clk) begin
        if (!rst_n)           cnt_q <= '0;
        else if (start_i)     cnt_q <= CW'(1);
        else if (inc_i && cnt_q != SAT) cnt_q <= cnt_q + 1'b1;
    end

    assign long_o = (cnt_q >= SAT);

    a_r4_increment: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_i && !start_i && cnt_q < SAT) |=> cnt_q == $past(cnt_q) + 1'b1);
    a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_i && cnt_q == SAT) |=> cnt_q == SAT);
    a_r8_restart: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> cnt_q == CW'(1));
endmodule

// File: rtl/holdoff_timer.sv
// Down-counter for the post-defect hold-off, in frames.
// Assumes load_val_i is between 1 and HOLD_MAX and that dec_i is used only while the count is nonzero.
module holdoff_timer #(
    parameter int unsigned HOLD_MAX = 16,
    localparam int unsigned HW = $clog2(HOLD_MAX + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [HW-1:0] load_val_i,
    input  logic          dec_i,
    input  logic          clear_i,
    output logic          last_o
);
    logic [HW-1:0] remain_q;

    // Remaining frames: load on fall, clear on new defect, count down per strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)                       remain_q <= '0;
        else if (clear_i)                 remain_q <= '0;
        else if (load_i)                  remain_q <= load_val_i;
        else if (dec_i && remain_q != '0) remain_q <= remain_q - 1'b1;
    end

    assign last_o = (remain_q == HW'(1));

    a_r5_load: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && !clear_i) |=> remain_q == $past(load_val_i));
    a_r6_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        remain_q <= HW'(HOLD_MAX));
    a_r8_cancel: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> remain_q == '0);
endmodule

// File: rtl/pll_handover_timer.sv
// Decides when clock recovery returns from the digital PLL to the analog PLL.
// Assumes frame_tick is a single-cycle strobe; inputs are used only when it is high.
module pll_handover_timer #(
    parameter int unsigned LONG_THRESH = 12,
    parameter int unsigned SHORT_HOLD  = 8,
    parameter int unsigned LONG_HOLD   = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_tick,
    input  logic defect_in,
    input  logic narrow_range,
    output logic dpll_active
);
    import pll_handover_pkg::*;

    localparam int unsigned HW = $clog2(LONG_HOLD + 1);
    localparam logic [HW-1:0] H_SW = HW'(SHORT_HOLD);
    localparam logic [HW-1:0] H_LW = HW'(LONG_HOLD);
    localparam logic [HW-1:0] H_SN = HW'(SHORT_HOLD / 2);
    localparam logic [HW-1:0] H_LN = HW'(LONG_HOLD / 2);

    phase_e        phase_q, phase_d;
    logic          w_start, w_inc, w_long;
    logic          h_load, h_dec, h_clear, h_last;
    logic [HW-1:0] h_val;

    // Next-phase and counter-control decode, acting on frame strobes only.
    always_comb begin
        phase_d = phase_q;
        w_start = 1'b0;
        w_inc   = 1'b0;
        h_load  = 1'b0;
        h_dec   = 1'b0;
        h_clear = 1'b0;
        if (frame_tick) begin
            unique case (phase_q)
                PH_IDLE: if (defect_in) begin
                    phase_d = PH_DEFECT;
                    w_start = 1'b1;
                end
                PH_DEFECT: if (defect_in) begin
                    w_inc = 1'b1;
                end else begin
                    phase_d = PH_HOLD;
                    h_load  = 1'b1;
                end
                PH_HOLD: if (defect_in) begin
                    phase_d = PH_DEFECT;
                    w_start = 1'b1;
                    h_clear = 1'b1;
                end else if (h_last) begin
                    phase_d = PH_IDLE;
                end else begin
                    h_dec = 1'b1;
                end
                default: phase_d = PH_IDLE;
            endcase
        end
    end

    // Hold-off length chosen from the measured width and the range input.
    always_comb begin
        unique case ({narrow_range, w_long})
            2'b00:   h_val = H_SW;
            2'b01:   h_val = H_LW;
            2'b10:   h_val = H_SN;
            default: h_val = H_LN;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= PH_IDLE;
        else        phase_q <= phase_d;
    end

    assign dpll_active = (phase_q != PH_IDLE);

    defect_width_meter #(.LONG_THRESH(LONG_THRESH)) u_width (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (w_start),
        .inc_i   (w_inc),
        .long_o  (w_long)
    );

    holdoff_timer #(.HOLD_MAX(LONG_HOLD)) u_hold (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (h_load),
        .load_val_i (h_val),
        .dec_i      (h_dec),
        .clear_i    (h_clear),
        .last_o     (h_last)
    );

    a_r1_reset: assert property (@(posedge clk)
        !rst_n |=> !dpll_active);
    a_r3_enter: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_tick && defect_in) |=> dpll_active);
    a_r9_tick_only: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && dpll_active != $past(dpll_active)) |-> $past(frame_tick));
    a_r8_stay_on: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_HOLD && frame_tick && defect_in) |=> phase_q == PH_DEFECT);
    a_r5_expire: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_HOLD && frame_tick && !defect_in && h_last) |=> !dpll_active);
endmodule

// File: tb/pll_handover_timer_tb.sv
// Directed bench: one task per scenario, each checking its own results.
module pll_handover_timer_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic frame_tick = 1'b0;
    logic defect_in = 1'b0;
    logic narrow_range = 1'b0;
    logic dpll_active;
    int   n_checks = 0;
    int   n_fail = 0;
    bit   done = 1'b0;

    always #2.5 clk = ~clk;

    pll_handover_timer u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .frame_tick   (frame_tick),
        .defect_in    (defect_in),
        .narrow_range (narrow_range),
        .dpll_active  (dpll_active)
    );

    task automatic check(input logic act, input logic exp, input string tag);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: dpll_active=%0b expected %0b", tag, act, exp);
        end
    endtask

    // One frame strobe with defect d and range r; idle cycles between
    // strobes drive the opposite values (R2) and must not move the output (R9).
    task automatic frame(input logic d, input logic r, output logic got);
        @(negedge clk);
        frame_tick = 1'b1; defect_in = d; narrow_range = r;
        @(negedge clk);
        frame_tick = 1'b0; defect_in = ~d; narrow_range = ~r;
        got = dpll_active;
        repeat (2) begin
            @(negedge clk);
            check(dpll_active, got, "R2/R9 no change between strobes");
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); @(negedge clk);
        check(dpll_active, 1'b0, "R1 reset");
        rst_n = 1'b1;
    endtask

    // Defect of 'width' frames, then hold-off with range r at the fall strobe;
    // range is inverted during the hold-off (R10).
    task automatic run_defect(input int width, input logic r, input int hold, input string tag);
        logic g;
        for (int i = 0; i < width; i++) begin
            frame(1'b1, ~r, g);
            check(g, 1'b1, "R3 active during defect");
        end
        frame(1'b0, r, g);
        check(g, 1'b1, {tag, " fall strobe"});
        for (int k = 1; k <= hold; k++) begin
            frame(1'b0, ~r, g);
            check(g, (k < hold) ? 1'b1 : 1'b0, {tag, " hold-off R10"});
        end
    endtask

    task automatic t_idle_ignore();
        logic g;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk); defect_in = i[0]; narrow_range = i[1];
            check(dpll_active, 1'b0, "R2 no strobe, no effect");
        end
        frame(1'b0, 1'b0, g);
        check(g, 1'b0, "R2 idle strobe");
    endtask

    task automatic t_redefect();
        logic g;
        for (int i = 0; i < 14; i++) frame(1'b1, 1'b0, g);
        frame(1'b0, 1'b0, g);
        for (int k = 0; k < 5; k++) frame(1'b0, 1'b0, g);
        frame(1'b1, 1'b0, g);
        check(g, 1'b1, "R8 re-defect keeps active");
        run_defect(1, 1'b0, 8, "R8 restarted width short");
    endtask

    task automatic t_reset_mid_hold();
        logic g;
        for (int i = 0; i < 3; i++) frame(1'b1, 1'b0, g);
        frame(1'b0, 1'b0, g);
        frame(1'b0, 1'b0, g);
        check(g, 1'b1, "R1 pre-reset hold active");
        do_reset();
        frame(1'b0, 1'b0, g);
        check(g, 1'b0, "R1 hold cleared by reset");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++; n_checks++;
            $display("FAIL watchdog: run hung");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        do_reset();
        t_idle_ignore();
        run_defect(3,  1'b0, 8,  "R5 short wide");
        run_defect(11, 1'b0, 8,  "R4 R5 width 11 short");
        run_defect(12, 1'b0, 16, "R4 R6 width 12 long");
        run_defect(40, 1'b0, 16, "R4 R6 saturated long");
        run_defect(5,  1'b1, 4,  "R7 short narrow");
        run_defect(12, 1'b1, 8,  "R7 long narrow");
        t_redefect();
        t_reset_mid_hold();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule